// File: doc/BRIEF.md
# Write-Through Dual-Port L1 Data Cache

A small set-associative data cache for integer loads. It holds 16 KB in 4 ways of 64-byte lines and is read and written in 32-bit words. Two load ports and two store ports work in the same cycle. A load that hits returns its word one cycle after the request. A load that misses reports the miss and raises a line request toward the next level, which later returns a full line on the fill port.

Every store is passed to the next level whether it hits or misses, so lines never hold data the next level lacks. A line carries only a valid bit. A store that misses leaves the cache untouched. The set is picked from low virtual address bits, and each lookup compares against a physical tag supplied beside the address. A fill that finds no free way evicts a way chosen by a per-set binary-tree pseudo-LRU.

Top module: `l1d_wt_cache`

## Requirements
- R1: Geometry is 64 sets x 4 ways x 64-byte lines with 32-bit words. The set is va[11:6], the word within the line is va[5:2] and va[1:0] is ignored. Fill data word w sits at fill_data_i[32w+31:32w].
- R2: A load on port p taken at edge N sets ld_ack_o[p] for the cycle after N. ld_hit_o[p] is 1 on a valid tag match, and ld_data_o[p] then holds the stored word. Both load ports work independently in the same cycle.
- R3: Every store on port p taken at edge N sets wt_valid_o[p] for the next cycle, whether it hits or misses. wt_addr_o[p] is {tag, va[11:2], 2'b00} and wt_data_o[p] is the store data.
- R4: A store miss allocates nothing. Line valid bits change only on a fill or a reset, so a later load to that address still misses.
- R5: A load miss sets mreq_valid_o[p] in the same cycle as its ack. mreq_addr_o[p] is the line address {tag, set, 6'b0}.
- R6: A store hit updates the word at the clock edge. A load to the same word in the same cycle returns the old value, and later loads return the new value.
- R7: When both store ports hit the same word in the same cycle, the value from port 1 is kept.
- R8: A fill whose tag is already resident in the set overwrites that way. Otherwise it goes to the lowest-numbered invalid way. If every way is valid it goes to the pseudo-LRU victim. The filled line is valid and hits on the next cycle.
- R9: Pseudo-LRU is a 3-node binary tree per set. Each node points away from the half that was used last, and load hits and fills count as uses. After ways 0..3 are filled in order and way 0 then hits, the victim is way 2.
- R10: After reset every line is invalid and ld_ack_o, mreq_valid_o and wt_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 2 | Load request per port |
| ld_va_i | input | 2x12 | Load virtual address bits per port |
| ld_tag_i | input | 2x20 | Load physical tag per port |
| ld_ack_o | output | 2 | Load result valid per port |
| ld_hit_o | output | 2 | Load hit per port |
| ld_data_o | output | 2x32 | Load data per port |
| mreq_valid_o | output | 2 | Line request for a load miss per port |
| mreq_addr_o | output | 2x32 | Requested line address per port |
| st_valid_i | input | 2 | Store request per port |
| st_va_i | input | 2x12 | Store virtual address bits per port |
| st_tag_i | input | 2x20 | Store physical tag per port |
| st_data_i | input | 2x32 | Store data per port |
| wt_valid_o | output | 2 | Write-through to the next level per port |
| wt_addr_o | output | 2x32 | Write-through word address per port |
| wt_data_o | output | 2x32 | Write-through data per port |
| fill_valid_i | input | 1 | Line fill from the next level |
| fill_va_i | input | 12 | Fill virtual address (set bits used) |
| fill_tag_i | input | 20 | Fill physical tag |
| fill_data_i | input | 512 | Fill line data |

## Verification
Load acks, hit flags, load data, miss requests and write-throughs all appear in the cycle after the edge that takes the request. Lookups finish within that one cycle, so nothing is due later. The bench drives inputs on a falling edge, lets exactly one rising edge pass, and reads the outputs on the next falling edge. It then withdraws the stimulus before the following rising edge. Effects that act on state, such as a store updating a word, a fill placing a line, or a hit moving the pseudo-LRU, are checked by a load in the next such cycle.

// File: rtl/l1d_pkg.sv
package l1d_pkg;
  localparam int unsigned DEF_CAP_BYTES  = 16384;
  localparam int unsigned DEF_LINE_BYTES = 64;
  localparam int unsigned DEF_WAYS       = 4;
  localparam int unsigned DEF_DATA_W     = 32;
  localparam int unsigned DEF_TAG_W      = 20;
  localparam int unsigned MAX_WAYS       = 16;

  typedef logic [MAX_WAYS-1:0] plru_t;

  // walk the tree from the root following node bits; leaf index is the victim
  function automatic logic [3:0] plru_pick(plru_t st, int unsigned lvls);
    logic [4:0] n;
    n = '0;
    for (int unsigned l = 0; l < lvls; l++)
      n = {n[3:0], 1'b1} + {4'b0, st[n[3:0]]};
    return 4'(n - 5'((1 << lvls) - 1));
  endfunction

  // point each node on the path away from the used way
  function automatic plru_t plru_touch(plru_t st, logic [3:0] way, int unsigned lvls);
    plru_t      r;
    logic [4:0] n;
    logic [3:0] sh;
    r = st;
    n = '0;
    for (int unsigned l = 0; l < lvls; l++) begin
      sh = way >> (lvls - 1 - l);
      r[n[3:0]] = ~sh[0];
      n = {n[3:0], 1'b1} + {4'b0, sh[0]};
    end
    return r;
  endfunction
endpackage

// File: rtl/l1d_tag_match.sv
module l1d_tag_match #(
  parameter  int unsigned WAYS  = 4,
  parameter  int unsigned TAG_W = 20,
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [WAYS-1:0]             valid_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            way_o
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid_i[w] && (tags_i[w] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) way_o = WAY_W'(w);
  end
  assign hit_o = |match;

  // R8: a tag is never resident in two ways of one set
  a_r8_single_way: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match));
endmodule

// File: rtl/l1d_plru.sv
module l1d_plru
  import l1d_pkg::*;
#(
  parameter  int unsigned SETS  = 64,
  parameter  int unsigned WAYS  = 4,
  parameter  int unsigned NT    = 3,
  localparam int unsigned IDX_W = $clog2(SETS),
  localparam int unsigned WAY_W = $clog2(WAYS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NT-1:0]              touch_en_i,
  input  logic [NT-1:0][IDX_W-1:0]   touch_set_i,
  input  logic [NT-1:0][WAY_W-1:0]   touch_way_i,
  input  logic [IDX_W-1:0]           vic_set_i,
  output logic [WAY_W-1:0]           vic_way_o
);
  plru_t st_q [SETS];
  plru_t st_d [SETS];

  // touches applied in port order; later index sees earlier updates
  always_comb begin
    st_d = st_q;
    for (int t = 0; t < NT; t++)
      if (touch_en_i[t])
        st_d[touch_set_i[t]] = plru_touch(st_d[touch_set_i[t]], 4'(touch_way_i[t]), WAY_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign vic_way_o = WAY_W'(plru_pick(st_q[vic_set_i], WAY_W));
endmodule

// File: rtl/l1d_wt_stage.sv
module l1d_wt_stage #(
  parameter int unsigned NST    = 2,
  parameter int unsigned PA_W   = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NST-1:0]               st_valid_i,
  input  logic [NST-1:0][PA_W-1:0]     st_addr_i,
  input  logic [NST-1:0][DATA_W-1:0]   st_data_i,
  output logic [NST-1:0]               wt_valid_o,
  output logic [NST-1:0][PA_W-1:0]     wt_addr_o,
  output logic [NST-1:0][DATA_W-1:0]   wt_data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wt_valid_o <= '0;
      wt_addr_o  <= '0;
      wt_data_o  <= '0;
    end else begin
      wt_valid_o <= st_valid_i;
      for (int p = 0; p < NST; p++)
        if (st_valid_i[p]) begin
          wt_addr_o[p] <= st_addr_i[p];
          wt_data_o[p] <= st_data_i[p];
        end
    end
  end

  for (genvar p = 0; p < NST; p++) begin : g_chk
    // R3: every store, hit or miss, reaches the next level one cycle later
    a_r3_every_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_valid_i[p] |=> wt_valid_o[p] && wt_data_o[p] == $past(st_data_i[p]));
  end
endmodule

// File: rtl/l1d_wt_cache.sv
module l1d_wt_cache
  import l1d_pkg::*;
#(
  parameter  int unsigned CAP_BYTES  = DEF_CAP_BYTES,
  parameter  int unsigned LINE_BYTES = DEF_LINE_BYTES,
  parameter  int unsigned WAYS       = DEF_WAYS,
  parameter  int unsigned DATA_W     = DEF_DATA_W,
  parameter  int unsigned TAG_W      = DEF_TAG_W,
  parameter  int unsigned NLD        = 2,
  parameter  int unsigned NST        = 2,
  localparam int unsigned SETS   = CAP_BYTES / (LINE_BYTES * WAYS),
  localparam int unsigned IDX_W  = $clog2(SETS),
  localparam int unsigned OFF_W  = $clog2(LINE_BYTES),
  localparam int unsigned WB_W   = $clog2(DATA_W / 8),
  localparam int unsigned WO_W   = OFF_W - WB_W,
  localparam int unsigned VA_W   = IDX_W + OFF_W,
  localparam int unsigned PA_W   = TAG_W + VA_W,
  localparam int unsigned LINE_W = LINE_BYTES * 8,
  localparam int unsigned WAY_W  = $clog2(WAYS),
  localparam int unsigned NLK    = NLD + NST + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NLD-1:0]               ld_valid_i,
  input  logic [NLD-1:0][VA_W-1:0]     ld_va_i,
  input  logic [NLD-1:0][TAG_W-1:0]    ld_tag_i,
  output logic [NLD-1:0]               ld_ack_o,
  output logic [NLD-1:0]               ld_hit_o,
  output logic [NLD-1:0][DATA_W-1:0]   ld_data_o,
  output logic [NLD-1:0]               mreq_valid_o,
  output logic [NLD-1:0][PA_W-1:0]     mreq_addr_o,
  input  logic [NST-1:0]               st_valid_i,
  input  logic [NST-1:0][VA_W-1:0]     st_va_i,
  input  logic [NST-1:0][TAG_W-1:0]    st_tag_i,
  input  logic [NST-1:0][DATA_W-1:0]   st_data_i,
  output logic [NST-1:0]               wt_valid_o,
  output logic [NST-1:0][PA_W-1:0]     wt_addr_o,
  output logic [NST-1:0][DATA_W-1:0]   wt_data_o,
  input  logic                         fill_valid_i,
  input  logic [VA_W-1:0]              fill_va_i,
  input  logic [TAG_W-1:0]             fill_tag_i,
  input  logic [LINE_W-1:0]            fill_data_i
);
  // storage
  logic [WAYS-1:0]              valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q   [SETS];
  logic [WAYS-1:0][LINE_W-1:0]  data_q  [SETS];

  // lookup channels: loads, then stores, then fill
  logic [NLK-1:0][IDX_W-1:0] lk_set;
  logic [NLK-1:0][TAG_W-1:0] lk_tag;
  logic [NLK-1:0]            lk_hit;
  logic [NLK-1:0][WAY_W-1:0] lk_way;

  always_comb begin
    for (int p = 0; p < NLD; p++) begin
      lk_set[p] = ld_va_i[p][VA_W-1:OFF_W];
      lk_tag[p] = ld_tag_i[p];
    end
    for (int p = 0; p < NST; p++) begin
      lk_set[NLD+p] = st_va_i[p][VA_W-1:OFF_W];
      lk_tag[NLD+p] = st_tag_i[p];
    end
    lk_set[NLK-1] = fill_va_i[VA_W-1:OFF_W];
    lk_tag[NLK-1] = fill_tag_i;
  end

  for (genvar i = 0; i < NLK; i++) begin : g_lk
    l1d_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) i_match (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tags_i  (tag_q[lk_set[i]]),
      .valid_i (valid_q[lk_set[i]]),
      .tag_i   (lk_tag[i]),
      .hit_o   (lk_hit[i]),
      .way_o   (lk_way[i])
    );
  end

  // fill way choice: resident tag, else lowest invalid, else pseudo-LRU
  logic [IDX_W-1:0] f_set;
  logic [WAY_W-1:0] f_way, vic_way, inv_way;
  logic             has_inv;

  assign f_set = lk_set[NLK-1];

  always_comb begin
    has_inv = 1'b0;
    inv_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!valid_q[f_set][w]) begin
        has_inv = 1'b1;
        inv_way = WAY_W'(w);
      end
    if (lk_hit[NLK-1])  f_way = lk_way[NLK-1];
    else if (has_inv)   f_way = inv_way;
    else                f_way = vic_way;
  end

  logic [NLD:0]              tch_en;
  logic [NLD:0][IDX_W-1:0]   tch_set;
  logic [NLD:0][WAY_W-1:0]   tch_way;

  always_comb begin
    for (int p = 0; p < NLD; p++) begin
      tch_en[p]  = ld_valid_i[p] && lk_hit[p];
      tch_set[p] = lk_set[p];
      tch_way[p] = lk_way[p];
    end
    tch_en[NLD]  = fill_valid_i;
    tch_set[NLD] = f_set;
    tch_way[NLD] = f_way;
  end

  l1d_plru #(.SETS(SETS), .WAYS(WAYS), .NT(NLD+1)) i_plru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (tch_en),
    .touch_set_i (tch_set),
    .touch_way_i (tch_way),
    .vic_set_i   (f_set),
    .vic_way_o   (vic_way)
  );

  // valid state: reset and fill only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (fill_valid_i) begin
      valid_q[f_set][f_way] <= 1'b1;
    end
  end

  // data and tags; port order gives the higher store port priority, fill last
  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NST; p++)
      if (st_valid_i[p] && lk_hit[NLD+p])
        data_q[lk_set[NLD+p]][lk_way[NLD+p]][st_va_i[p][OFF_W-1:WB_W]*DATA_W +: DATA_W]
          <= st_data_i[p];
    if (fill_valid_i) begin
      tag_q[f_set][f_way]  <= fill_tag_i;
      data_q[f_set][f_way] <= fill_data_i;
    end
  end

  // load result stage: reads precede this edge's store writes
  logic [NLD-1:0][DATA_W-1:0] ld_rdata;
  logic [NLD-1:0][WO_W-1:0]   ld_word;

  always_comb begin
    for (int p = 0; p < NLD; p++) begin
      ld_word[p]  = ld_va_i[p][OFF_W-1:WB_W];
      ld_rdata[p] = data_q[lk_set[p]][lk_way[p]][ld_word[p]*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_ack_o     <= '0;
      ld_hit_o     <= '0;
      ld_data_o    <= '0;
      mreq_valid_o <= '0;
      mreq_addr_o  <= '0;
    end else begin
      for (int p = 0; p < NLD; p++) begin
        ld_ack_o[p]     <= ld_valid_i[p];
        ld_hit_o[p]     <= ld_valid_i[p] && lk_hit[p];
        mreq_valid_o[p] <= ld_valid_i[p] && !lk_hit[p];
        if (ld_valid_i[p] && lk_hit[p])  ld_data_o[p]   <= ld_rdata[p];
        if (ld_valid_i[p] && !lk_hit[p]) mreq_addr_o[p] <= {ld_tag_i[p], lk_set[p], OFF_W'(0)};
      end
    end
  end

  // write-through
  logic [NST-1:0][PA_W-1:0] st_pa;
  always_comb
    for (int p = 0; p < NST; p++)
      st_pa[p] = {st_tag_i[p], st_va_i[p][VA_W-1:WB_W], WB_W'(0)};

  l1d_wt_stage #(.NST(NST), .PA_W(PA_W), .DATA_W(DATA_W)) i_wt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_valid_i (st_valid_i),
    .st_addr_i  (st_pa),
    .st_data_i  (st_data_i),
    .wt_valid_o (wt_valid_o),
    .wt_addr_o  (wt_addr_o),
    .wt_data_o  (wt_data_o)
  );

  // checks
  logic [SETS*WAYS-1:0] valid_flat;
  for (genvar s = 0; s < SETS; s++) begin : g_vf
    assign valid_flat[s*WAYS +: WAYS] = valid_q[s];
  end

  // R4: valid bits move only on fills
  a_r4_valid_only_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fill_valid_i |=> $stable(valid_flat));

  // R8: a filled line is valid after the edge
  a_r8_fill_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_i |=> valid_q[$past(f_set)][$past(f_way)]);

  for (genvar p = 0; p < NLD; p++) begin : g_ldchk
    // R2: one ack per load, exactly one cycle later
    a_r2_ack_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_valid_i[p] |=> ld_ack_o[p]);
    // R5: an acked miss carries a line request
    a_r5_miss_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ld_ack_o[p] && !ld_hit_o[p] |-> mreq_valid_o[p]);
  end
endmodule

// File: tb/test_l1d_wt_cache.sv
module test_l1d_wt_cache;
  localparam int TAG_W = 20, DATA_W = 32, VA_W = 12, PA_W = 32, LINE_W = 512;

  logic clk_i = 1'b0;
  logic rst_ni;
  always #5 clk_i = ~clk_i;

  logic [1:0]             ld_valid_i, ld_ack_o, ld_hit_o, mreq_valid_o;
  logic [1:0][VA_W-1:0]   ld_va_i;
  logic [1:0][TAG_W-1:0]  ld_tag_i;
  logic [1:0][DATA_W-1:0] ld_data_o;
  logic [1:0][PA_W-1:0]   mreq_addr_o;
  logic [1:0]             st_valid_i, wt_valid_o;
  logic [1:0][VA_W-1:0]   st_va_i;
  logic [1:0][TAG_W-1:0]  st_tag_i;
  logic [1:0][DATA_W-1:0] st_data_i, wt_data_o;
  logic [1:0][PA_W-1:0]   wt_addr_o;
  logic                   fill_valid_i;
  logic [VA_W-1:0]        fill_va_i;
  logic [TAG_W-1:0]       fill_tag_i;
  logic [LINE_W-1:0]      fill_data_i;

  l1d_wt_cache i_l1d_wt_cache (.*);

  int n_chk = 0, n_err = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(logic [19:0] tag, int set, int w);
    return {tag[15:0], 2'b00, 6'(set), 4'(w), 4'ha};
  endfunction

  function automatic logic [LINE_W-1:0] line_of(logic [19:0] tag, int set);
    logic [LINE_W-1:0] l;
    for (int w = 0; w < 16; w++) l[w*32 +: 32] = pat(tag, set, w);
    return l;
  endfunction

  task automatic idle();
    ld_valid_i = '0; ld_va_i = '0; ld_tag_i = '0;
    st_valid_i = '0; st_va_i = '0; st_tag_i = '0; st_data_i = '0;
    fill_valid_i = 1'b0; fill_va_i = '0; fill_tag_i = '0; fill_data_i = '0;
  endtask

  task automatic drv_ld(int p, int set, logic [19:0] tag, int w);
    ld_valid_i[p] = 1'b1; ld_va_i[p] = {6'(set), 4'(w), 2'b00}; ld_tag_i[p] = tag;
  endtask

  task automatic drv_st(int p, int set, logic [19:0] tag, int w, logic [31:0] d);
    st_valid_i[p] = 1'b1; st_va_i[p] = {6'(set), 4'(w), 2'b00}; st_tag_i[p] = tag; st_data_i[p] = d;
  endtask

  task automatic drv_fill(int set, logic [19:0] tag);
    fill_valid_i = 1'b1; fill_va_i = {6'(set), 6'd0}; fill_tag_i = tag; fill_data_i = line_of(tag, set);
  endtask

  // one rising edge, outputs read on the following falling edge
  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic ld_chk(string req, int p, int set, logic [19:0] tag, int w, logic hit, logic [31:0] d);
    idle(); drv_ld(p, set, tag, w); tick(); idle();
    chk(req, {63'd0, ld_ack_o[p]}, 64'd1);
    chk(req, {63'd0, ld_hit_o[p]}, {63'd0, hit});
    if (hit) chk(req, {32'd0, ld_data_o[p]}, {32'd0, d});
    else     chk(req, {32'd0, mreq_addr_o[p]}, {32'd0, tag, 6'(set), 6'd0});
  endtask

  localparam logic [19:0] TA = 20'h1a1a1, TB = 20'h2b2b2, TC = 20'h3c3c3, TD = 20'h4d4d4,
                          TE = 20'h5e5e5, TF = 20'h6f6f6;

  typedef struct packed {
    logic [1:0]  op;     // 0 load, 1 store, 2 fill
    logic        port;
    logic [5:0]  set;
    logic [19:0] tag;
    logic [3:0]  word;
    logic [31:0] data;
    logic        hit;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd2, 1'b0, 6'd3, TA, 4'd0,  32'h0,        1'b0, 32'h0},           // R8 fill into empty set
    '{2'd0, 1'b0, 6'd3, TA, 4'd2,  32'h0,        1'b1, pat(TA, 3, 2)},   // R2 R1 hit port 0
    '{2'd0, 1'b1, 6'd3, TA, 4'd15, 32'h0,        1'b1, pat(TA, 3, 15)},  // R2 R1 hit port 1 last word
    '{2'd0, 1'b0, 6'd3, TB, 4'd0,  32'h0,        1'b0, 32'h0},           // R5 miss
    '{2'd1, 1'b1, 6'd3, TA, 4'd2,  32'hdeadbeef, 1'b0, 32'h0},           // R3 store hit
    '{2'd0, 1'b0, 6'd3, TA, 4'd2,  32'h0,        1'b1, 32'hdeadbeef},    // R6 updated word
    '{2'd1, 1'b0, 6'd7, TC, 4'd1,  32'h12345678, 1'b0, 32'h0},           // R3 store miss
    '{2'd0, 1'b1, 6'd7, TC, 4'd1,  32'h0,        1'b0, 32'h0},           // R4 no allocate
    '{2'd2, 1'b0, 6'd3, TB, 4'd0,  32'h0,        1'b0, 32'h0},           // R8 second way
    '{2'd0, 1'b1, 6'd3, TB, 4'd9,  32'h0,        1'b1, pat(TB, 3, 9)}    // R8 hit after fill
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL watchdog act=running exp=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    tick();
    // R10 reset state
    chk("R10 ack", {62'd0, ld_ack_o}, 64'd0);
    chk("R10 wt", {62'd0, wt_valid_o}, 64'd0);
    chk("R10 mreq", {62'd0, mreq_valid_o}, 64'd0);
    ld_chk("R10 empty", 0, 3, TA, 0, 1'b0, 32'h0);

    for (int i = 0; i < NV; i++) begin
      idle();
      case (VEC[i].op)
        2'd0: drv_ld(int'(VEC[i].port), int'(VEC[i].set), VEC[i].tag, int'(VEC[i].word));
        2'd1: drv_st(int'(VEC[i].port), int'(VEC[i].set), VEC[i].tag, int'(VEC[i].word), VEC[i].data);
        default: drv_fill(int'(VEC[i].set), VEC[i].tag);
      endcase
      tick();
      idle();
      if (VEC[i].op == 2'd0) begin
        chk($sformatf("R2 vec%0d ack", i), {63'd0, ld_ack_o[VEC[i].port]}, 64'd1);
        chk($sformatf("R2 vec%0d hit", i), {63'd0, ld_hit_o[VEC[i].port]}, {63'd0, VEC[i].hit});
        if (VEC[i].hit)
          chk($sformatf("R2 vec%0d data", i), {32'd0, ld_data_o[VEC[i].port]}, {32'd0, VEC[i].exp});
        else begin
          chk($sformatf("R5 vec%0d mreq", i), {63'd0, mreq_valid_o[VEC[i].port]}, 64'd1);
          chk($sformatf("R5 vec%0d addr", i), {32'd0, mreq_addr_o[VEC[i].port]},
              {32'd0, VEC[i].tag, VEC[i].set, 6'd0});
        end
      end else if (VEC[i].op == 2'd1) begin
        chk($sformatf("R3 vec%0d wt", i), {63'd0, wt_valid_o[VEC[i].port]}, 64'd1);
        chk($sformatf("R3 vec%0d addr", i), {32'd0, wt_addr_o[VEC[i].port]},
            {32'd0, VEC[i].tag, VEC[i].set, VEC[i].word, 2'b00});
        chk($sformatf("R3 vec%0d data", i), {32'd0, wt_data_o[VEC[i].port]}, {32'd0, VEC[i].data});
      end
    end

    // R6: same-cycle load and store to one word gives old data
    idle(); drv_ld(0, 3, TA, 5); drv_st(0, 3, TA, 5, 32'hcafe0005); tick(); idle();
    chk("R6 old data", {32'd0, ld_data_o[0]}, {32'd0, pat(TA, 3, 5)});
    ld_chk("R6 new data", 1, 3, TA, 5, 1'b1, 32'hcafe0005);

    // R7: both store ports on one word, port 1 kept
    idle(); drv_st(0, 3, TB, 4, 32'haaaa0000); drv_st(1, 3, TB, 4, 32'hbbbb1111); tick(); idle();
    chk("R7 wt both", {62'd0, wt_valid_o}, 64'd3);
    ld_chk("R7 port1 wins", 0, 3, TB, 4, 1'b1, 32'hbbbb1111);

    // R2: both load ports in one cycle
    idle(); drv_ld(0, 3, TA, 0); drv_ld(1, 3, TB, 1); tick(); idle();
    chk("R2 dual p0", {32'd0, ld_data_o[0]}, {32'd0, pat(TA, 3, 0)});
    chk("R2 dual p1", {32'd0, ld_data_o[1]}, {32'd0, pat(TB, 3, 1)});

    // R9: pseudo-LRU in set 9
    foreach (VEC[k]) if (k < 0) idle();
    idle(); drv_fill(9, TA); tick();
    idle(); drv_fill(9, TB); tick();
    idle(); drv_fill(9, TC); tick();
    idle(); drv_fill(9, TD); tick(); idle();
    ld_chk("R9 touch way0", 0, 9, TA, 3, 1'b1, pat(TA, 9, 3));
    idle(); drv_fill(9, TE); tick(); idle();
    ld_chk("R9 victim way2 evicted", 0, 9, TC, 0, 1'b0, 32'h0);
    ld_chk("R9 new line", 1, 9, TE, 6, 1'b1, pat(TE, 9, 6));
    // R8: resident tag refilled in place, then victim is way3
    idle(); drv_fill(9, TA); tick();
    idle(); drv_fill(9, TF); tick(); idle();
    ld_chk("R8 D evicted", 0, 9, TD, 0, 1'b0, 32'h0);
    ld_chk("R8 B kept", 1, 9, TB, 2, 1'b1, pat(TB, 9, 2));
    ld_chk("R8 F hit", 0, 9, TF, 7, 1'b1, pat(TF, 9, 7));
    ld_chk("R8 A hit", 1, 9, TA, 8, 1'b1, pat(TA, 9, 8));

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule